// File: doc/BRIEF.md
# Parallel Prefix Mux Chain Evaluator

This block evaluates a chain of N two-input multiplexers in logarithmic depth. Stage k holds two data bits, `a_i[k]` and `b_i[k]`. Its select comes from the output of stage k-1. For stage 0, the select is the external `seed_i`. A plain ripple through such a chain grows by one mux delay per stage. This block avoids that growth.

Each stage is turned into a 2-bit transform code with the layout {force, value/invert}:

| Code | Transform |
|------|-----------|
| 00 | pass |
| 01 | invert |
| 10 | force 0 |
| 11 | force 1 |

Composing these transforms is associative. The codes are therefore combined over a Kogge-Stone prefix tree of log2(N) levels. Each prefix transform is then applied to the seed, so all N stage outputs appear together on `taps_o`.

The parameter `REG_OUT` selects the output variant:
- `REG_OUT = 1`: a register captures the tap vector on the rising clock edge, and a synchronous active-high reset clears it.
- `REG_OUT = 0`: the output is purely combinational.

The block has no flow control and no valid/ready handshake. A new input vector may be applied on every cycle, and the outputs follow the inputs without back-pressure. The clock and reset pins are used only when `REG_OUT = 1`.

Top module: `mux_chain_prefix`

## Requirements
- R1: Tap k equals `b_i[k]` when its select is 1 and `a_i[k]` when its select is 0. The select of stage 0 is `seed_i`, and the select of stage k>0 is tap k-1.
- R2: A stage with a=0, b=0 drives its tap to 0 whatever its select.
- R3: A stage with a=1, b=1 drives its tap to 1 whatever its select.
- R4: A stage with a=0, b=1 copies its select to its tap. A stage with a=1, b=0 drives the inverse of its select.
- R5: With every stage passing (all a=0, all b=1), every tap equals `seed_i`.
- R6: With every stage inverting (all a=1, all b=0), tap k equals `seed_i` XOR 1 when k is even, and `seed_i` when k is odd.
- R7: With `REG_OUT=1`, `taps_o` shows the result of the inputs sampled at the previous rising edge, and it does not change between edges. With `REG_OUT=0`, `taps_o` follows the inputs in the same cycle.
- R8: With `REG_OUT=1`, a high `rst` at a rising edge clears `taps_o` to all zeros, whatever the inputs.
- R9: Once a stage forces its tap (R2 or R3), that tap and every tap after it do not depend on `seed_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| seed_i | input | 1 | Select of stage 0 |
| a_i | input | N | Data taken by stage k when its select is 0 |
| b_i | input | N | Data taken by stage k when its select is 1 |
| taps_o | output | N | Output of every stage, bit k for stage k |

## Verification
The combinational variant's taps are due within the same cycle the inputs change. The bench reads them a short time after it drives new inputs on the falling edge. The registered variant's taps are due one rising edge later. The bench reads them on the following falling edge, and it also confirms that they still hold the previous vector before that edge. Every reading is compared in full against a ripple evaluation of the chain built from R1.

// File: rtl/mux_chain_pkg.sv
package mux_chain_pkg;
  // transform code: {force, value_or_invert}
  typedef logic [1:0] xform_t;

  localparam xform_t XF_PASS = 2'b00;
  localparam xform_t XF_INV  = 2'b01;
  localparam xform_t XF_ZERO = 2'b10;
  localparam xform_t XF_ONE  = 2'b11;

  // earlier applied first (nearer the seed), later applied after it
  function automatic xform_t xf_compose(xform_t earlier, xform_t later);
    xform_t r;
    if (later[1]) r = later;
    else          r = {earlier[1], earlier[0] ^ later[0]};
    return r;
  endfunction

  function automatic logic xf_apply(xform_t t, logic s);
    return t[1] ? t[0] : (s ^ t[0]);
  endfunction
endpackage

// File: rtl/mux_stage_encoder.sv
module mux_stage_encoder
  import mux_chain_pkg::*;
(
  input  logic   lo_i,
  input  logic   hi_i,
  output xform_t code_o
);
  // equal data forces the value; otherwise lo decides pass or invert
  assign code_o = {~(lo_i ^ hi_i), lo_i};
endmodule

// File: rtl/prefix_combine_cell.sv
module prefix_combine_cell
  import mux_chain_pkg::*;
(
  input  xform_t near_i,
  input  xform_t far_i,
  output xform_t comb_o
);
  assign comb_o = xf_compose(near_i, far_i);
endmodule

// File: rtl/kogge_stone_scan.sv
module kogge_stone_scan
  import mux_chain_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0][1:0] leaf_i,
  output logic [N-1:0][1:0] pref_o
);
  localparam int LVLS = (N > 1) ? $clog2(N) : 1;

  logic [LVLS:0][N-1:0][1:0] lvl;

  assign lvl[0] = leaf_i;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int DIST = 1 << l;
    for (genvar i = 0; i < N; i++) begin : g_col
      if (i >= DIST) begin : g_cell
        prefix_combine_cell u_cell (
          .near_i (lvl[l][i-DIST]),
          .far_i  (lvl[l][i]),
          .comb_o (lvl[l+1][i])
        );
      end else begin : g_wire
        assign lvl[l+1][i] = lvl[l][i];
      end
    end
  end

  assign pref_o = lvl[LVLS];
endmodule

// File: rtl/mux_chain_prefix.sv
module mux_chain_prefix
  import mux_chain_pkg::*;
#(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] taps_o
);
  localparam int LVLS = (N > 1) ? $clog2(N) : 1;

  initial assert ((1 << LVLS) == N || N == 1)
    else $error("N must be a power of two");

  logic [N-1:0][1:0] leaf;
  logic [N-1:0][1:0] pref;
  logic [N-1:0]      taps_now;

  for (genvar k = 0; k < N; k++) begin : g_enc
    mux_stage_encoder u_enc (
      .lo_i   (a_i[k]),
      .hi_i   (b_i[k]),
      .code_o (leaf[k])
    );
    assign taps_now[k] = xf_apply(pref[k], seed_i);
  end

  kogge_stone_scan #(.N(N)) u_scan (
    .leaf_i (leaf),
    .pref_o (pref)
  );

  if (REG_OUT) begin : g_reg
    logic [N-1:0] taps_q;
    always_ff @(posedge clk) begin
      if (rst) taps_q <= '0;
      else     taps_q <= taps_now;
    end
    assign taps_o = taps_q;

    assert_reg_delay_R7: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> taps_o == $past(taps_now));
    assert_reset_clear_R8: assert property (@(posedge clk)
      rst |=> taps_o == '0);
  end else begin : g_comb
    assign taps_o = taps_now;
  end

  // tree result must agree with a stage-by-stage view of the chain
  assert_first_stage_R1: assert property (@(posedge clk) disable iff (rst)
    taps_now[0] == (seed_i ? b_i[0] : a_i[0]));

  for (genvar k = 1; k < N; k++) begin : g_chk
    assert_link_R1: assert property (@(posedge clk) disable iff (rst)
      taps_now[k] == (taps_now[k-1] ? b_i[k] : a_i[k]));
  end

  for (genvar k = 0; k < N; k++) begin : g_force_chk
    assert_stop_R2: assert property (@(posedge clk) disable iff (rst)
      (!a_i[k] && !b_i[k]) |-> !taps_now[k]);
    assert_gen_R3: assert property (@(posedge clk) disable iff (rst)
      (a_i[k] && b_i[k]) |-> taps_now[k]);
  end
endmodule

// File: tb/tb_mux_chain_prefix.sv
module tb_mux_chain_prefix;
  localparam int N = 16;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         seed = 1'b0;
  logic [N-1:0] a = '0;
  logic [N-1:0] b = '0;
  logic [N-1:0] taps_r, taps_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_chain_prefix #(.N(N), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst(rst), .seed_i(seed), .a_i(a), .b_i(b), .taps_o(taps_r));

  mux_chain_prefix #(.N(N), .REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst(rst), .seed_i(seed), .a_i(a), .b_i(b), .taps_o(taps_c));

  // ripple evaluation following R1
  function automatic logic [N-1:0] ripple(logic [N-1:0] av, logic [N-1:0] bv, logic s);
    logic [N-1:0] t;
    logic sel = s;
    for (int k = 0; k < N; k++) begin
      t[k] = sel ? bv[k] : av[k];
      sel = t[k];
    end
    return t;
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on falling edge; comb due at once, registered after next rising edge
  task automatic apply(string req, logic [N-1:0] av, logic [N-1:0] bv, logic s,
                       logic [N-1:0] exp);
    @(negedge clk);
    a = av; b = bv; seed = s;
    #1;
    check({req, " comb"}, taps_c, exp);
    @(negedge clk);
    check({req, " reg"}, taps_r, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    a = '1; b = '1; seed = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset clears", taps_r, '0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 after release", taps_r, '1);
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      logic [N-1:0] av = N'($urandom);
      logic [N-1:0] bv = N'($urandom);
      logic s = 1'($urandom);
      apply("R1 random", av, bv, s, ripple(av, bv, s));
    end
  endtask

  task automatic t_single_stage();
    // stage 0 table, rest pass: R2 stop, R3 generate, R4 pass/invert
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 2; s++) begin
        logic av0 = c[0];
        logic bv0 = c[1];
        logic e;
        if (!av0 && !bv0)      e = 1'b0;          // R2
        else if (av0 && bv0)   e = 1'b1;          // R3
        else if (!av0 && bv0)  e = s[0];          // R4 pass
        else                   e = ~s[0];         // R4 invert
        apply("R2/R3/R4 stage0", {{(N-1){1'b0}}, av0}, {{(N-1){1'b1}}, bv0},
              s[0], {N{e}});
      end
    end
  endtask

  task automatic t_all_pass();
    apply("R5 all pass seed0", '0, '1, 1'b0, '0);
    apply("R5 all pass seed1", '0, '1, 1'b1, '1);
  endtask

  task automatic t_all_inv();
    logic [N-1:0] e0;
    for (int k = 0; k < N; k++) e0[k] = (k % 2 == 0);
    apply("R6 all invert seed0", '1, '0, 1'b0, e0);
    apply("R6 all invert seed1", '1, '0, 1'b1, ~e0);
  endtask

  task automatic t_force_seed();
    for (int i = 0; i < 8; i++) begin
      logic [N-1:0] av = N'($urandom);
      logic [N-1:0] bv = N'($urandom);
      int pos = i % N;
      logic [N-1:0] m0, m1, hi;
      av[pos] = i[0]; bv[pos] = i[0];
      hi = ~((N'(1) << pos) - N'(1));
      apply("R9 seed0", av, bv, 1'b0, ripple(av, bv, 1'b0));
      m0 = taps_r;
      apply("R9 seed1", av, bv, 1'b1, ripple(av, bv, 1'b1));
      m1 = taps_r;
      check("R9 seed independent", m1 & hi, m0 & hi);
    end
  endtask

  task automatic t_latency();
    logic [N-1:0] prev;
    apply("R7 setup", '0, '1, 1'b1, '1);
    prev = taps_r;
    @(negedge clk);
    a = '0; b = '0; seed = 1'b1;
    #1;
    check("R7 comb same cycle", taps_c, '0);
    check("R7 reg holds before edge", taps_r, prev);
    @(posedge clk);
    #1;
    check("R7 reg after edge", taps_r, '0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    t_reset();
    t_random();
    t_single_stage();
    t_all_pass();
    t_all_inv();
    t_force_seed();
    t_latency();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule